// File: doc/BRIEF.md
# Transport Stream Output Port

This block sits behind the error-correction chain of a digital broadcast receiver. It takes decoded 188-byte transport packets, one byte per transfer, and drives them onto an external MPEG transport stream port. That port has an output clock, a data-valid strobe, a packet-start sync strobe, an error strobe and 8 data lines. The upstream stage marks a packet it could not correct on the packet's first byte. The block then sets the transport error indicator in that packet's header and raises the error strobe for the whole packet.

The format is chosen at run time. In byte-parallel format a whole byte goes out in each output clock period. In bit-serial format the bits of each byte go out one per period on a single line. A format request is taken up only where a packet starts, so no packet is ever split between the two formats. A separate high-impedance request drops the pad drive enable so that the port can be released. The packet stream keeps running while the port is released.

The input is a valid/ready stream. A byte moves when `in_valid` and `in_ready` are both high at a rising clock edge. While `in_valid` is high and `in_ready` is low, the source must hold `in_data`, `in_sop` and `in_uncorr` steady. Back-pressure comes only from the output rate. `in_ready` drops after each accepted byte and returns in the last core cycle of that byte's final output period. This lets back-to-back bytes stream with no idle period between them.

Top module: `ts_stream_out`

## Requirements
- R1: A byte is taken only in a cycle where `in_valid` and `in_ready` are both high. In the cycle after a byte is taken, `in_ready` is low. `in_ready` is low while reset is held.
- R2: In parallel format (`mode_serial` = 0) each byte occupies one output period of two core cycles: `ts_clk` is low in the first cycle and high in the second. The full byte is on `ts_data[7:0]`, and the data does not change while `ts_clk` is high.
- R3: In serial format (`mode_serial` = 1) each byte occupies eight output periods. The most significant bit goes first on `ts_data[0]`, and `ts_data[7:1]` stay 0.
- R4: `ts_sync` is high only during the first output period of a packet. In parallel format this is the period carrying the first byte; in serial format it is the period carrying that byte's first bit.
- R5: `ts_err` is high for every output period of a packet whose first byte arrived with `in_uncorr` = 1. It is low for every period of other packets. `in_uncorr` on bytes other than the first is ignored.
- R6: For a flagged packet, bit 7 of the byte at index 1 (the second header byte) is forced to 1 and all other bits pass unchanged. No other byte, and no byte of an unflagged packet, is altered.
- R7: `mode_serial` is sampled together with the first byte of each packet. Changing it in the middle of a packet leaves the rest of that packet in the format already chosen.
- R8: `ts_oe` is low in the cycle after `out_hiz` is high and high in the cycle after `out_hiz` is low. The packet flow and the other outputs are unaffected by `out_hiz`.
- R9: While reset is held, `ts_clk`, `ts_valid`, `ts_sync`, `ts_err`, `ts_data` and `ts_oe` are 0. The next byte taken after reset is treated as the first byte of a packet.
- R10: When no byte is waiting at the end of an output period, `ts_valid` goes low and `ts_clk` stays low until the next byte is taken. The packet then resumes with no byte lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte available |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_uncorr | input | 1 | Packet uncorrectable; read on the first byte only |
| mode_serial | input | 1 | Requested format: 0 parallel, 1 serial |
| out_hiz | input | 1 | Request to release the output pads |
| ts_clk | output | 1 | Output port clock; data is stable while high |
| ts_valid | output | 1 | Output data valid |
| ts_sync | output | 1 | First output period of a packet |
| ts_err | output | 1 | Current packet is uncorrectable |
| ts_data | output | 8 | Output data lines; serial format uses bit 0 |
| ts_oe | output | 1 | Pad drive enable for all port outputs |

## Verification
The bench keeps the default parameters: 188-byte packets and an 8-bit data path. Every packet therefore runs at full length. This covers the index-1 header rewrite, the full 1504-period serial packet and the wrap of the byte counter back to a packet start. With the full packet length, a format change can be made well inside a packet, so the boundary rule is tested on a real mid-packet switch. Idle gaps placed between bytes, and uncorrectable flags toggled on non-first bytes, show that the output holds steady across stalls and that only the first byte's flag counts.

// File: rtl/ts_out_pkg.sv
package ts_out_pkg;
  typedef enum logic {
    FMT_PAR = 1'b0,
    FMT_SER = 1'b1
  } fmt_e;

  // header byte holding the transport error indicator
  localparam int unsigned TEI_BYTE_IDX = 1;
endpackage

// File: rtl/ts_pkt_tracker.sv
module ts_pkt_tracker
  import ts_out_pkg::*;
#(
  parameter int unsigned PKT_BYTES = 188,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_uncorr,
  input  logic              mode_serial,
  output logic [DATA_W-1:0] byte_out,
  output logic              first_out,
  output logic              err_out,
  output fmt_e              fmt_out
);
  localparam int unsigned IW      = $clog2(PKT_BYTES);
  localparam int unsigned TEI_POS = DATA_W - 1;

  logic [IW-1:0] idx_q;
  logic          err_q;
  fmt_e          fmt_q;
  logic          at_first;

  assign at_first  = (idx_q == '0);
  assign first_out = at_first;
  assign err_out   = at_first ? in_uncorr : err_q;
  assign fmt_out   = at_first ? fmt_e'(mode_serial) : fmt_q;

  always_comb begin
    byte_out = in_data;
    if (err_out && idx_q == IW'(TEI_BYTE_IDX)) byte_out[TEI_POS] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      err_q <= 1'b0;
      fmt_q <= FMT_PAR;
    end else if (take) begin
      idx_q <= (idx_q == IW'(PKT_BYTES - 1)) ? '0 : idx_q + 1'b1;
      if (at_first) begin
        err_q <= in_uncorr;
        fmt_q <= fmt_e'(mode_serial);
      end
    end
  end

  // source must mark the byte the tracker counts as packet start (R9)
  assert_sop_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    take && at_first |-> in_sop);
endmodule

// File: rtl/ts_symbol_engine.sv
module ts_symbol_engine
  import ts_out_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] ld_byte,
  input  logic              ld_first,
  input  logic              ld_err,
  input  fmt_e              ld_fmt,
  output logic              can_take,
  output logic              ts_clk,
  output logic              ts_valid,
  output logic              ts_sync,
  output logic              ts_err,
  output logic [DATA_W-1:0] ts_data
);
  localparam int unsigned CW = $clog2(DATA_W);

  logic              busy_q, phase_q, first_q, err_q;
  fmt_e              fmt_q;
  logic [DATA_W-1:0] sh_q;
  logic [CW-1:0]     bit_q;
  logic              last_sym;

  assign last_sym = (fmt_q == FMT_PAR) || (bit_q == CW'(DATA_W - 1));
  assign can_take = !busy_q || (phase_q && last_sym);

  assign ts_valid = busy_q;
  assign ts_clk   = busy_q & phase_q;
  assign ts_sync  = busy_q & first_q & (bit_q == '0);
  assign ts_err   = busy_q & err_q;

  always_comb begin
    ts_data = '0;
    if (busy_q) begin
      if (fmt_q == FMT_SER) ts_data[0] = sh_q[DATA_W-1];
      else                  ts_data    = sh_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      fmt_q   <= FMT_PAR;
      sh_q    <= '0;
      bit_q   <= '0;
    end else if (ld) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      first_q <= ld_first;
      err_q   <= ld_err;
      fmt_q   <= ld_fmt;
      sh_q    <= ld_byte;
      bit_q   <= '0;
    end else if (busy_q) begin
      phase_q <= ~phase_q;
      if (phase_q) begin
        if (last_sym) begin
          busy_q <= 1'b0;
        end else begin
          bit_q <= bit_q + 1'b1;
          sh_q  <= sh_q << 1;
        end
      end
    end
  end

  assert_clk_in_valid_R2: assert property (@(posedge clk) disable iff (rst)
    ts_clk |-> ts_valid);
  assert_data_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ts_clk |-> $stable(ts_data));
  assert_half_period_R2: assert property (@(posedge clk) disable iff (rst)
    ts_valid && !ts_clk |=> ts_clk);
  assert_sync_one_period_R4: assert property (@(posedge clk) disable iff (rst)
    ts_sync && ts_clk |=> !ts_sync);
  assert_err_steady_R5: assert property (@(posedge clk) disable iff (rst)
    ts_valid && $past(ts_valid) && !ts_sync |-> ts_err == $past(ts_err));
  assert_fmt_held_R7: assert property (@(posedge clk) disable iff (rst)
    ld && busy_q && !ld_first |-> ld_fmt == fmt_q);
  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (rst)
    ld |=> !can_take);
endmodule

// File: rtl/ts_stream_out.sv
module ts_stream_out
  import ts_out_pkg::*;
#(
  parameter int unsigned PKT_BYTES = 188,
  parameter int unsigned DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_uncorr,
  input  logic              mode_serial,
  input  logic              out_hiz,
  output logic              ts_clk,
  output logic              ts_valid,
  output logic              ts_sync,
  output logic              ts_err,
  output logic [DATA_W-1:0] ts_data,
  output logic              ts_oe
);
  logic              eng_can_take, take;
  logic [DATA_W-1:0] trk_byte;
  logic              trk_first, trk_err;
  fmt_e              trk_fmt;

  assign in_ready = eng_can_take & ~rst;
  assign take     = in_valid & in_ready;

  ts_pkt_tracker #(.PKT_BYTES(PKT_BYTES), .DATA_W(DATA_W)) trk_i (
    .clk(clk), .rst(rst), .take(take), .in_data(in_data), .in_sop(in_sop),
    .in_uncorr(in_uncorr), .mode_serial(mode_serial), .byte_out(trk_byte),
    .first_out(trk_first), .err_out(trk_err), .fmt_out(trk_fmt)
  );

  ts_symbol_engine #(.DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst(rst), .ld(take), .ld_byte(trk_byte), .ld_first(trk_first),
    .ld_err(trk_err), .ld_fmt(trk_fmt), .can_take(eng_can_take),
    .ts_clk(ts_clk), .ts_valid(ts_valid), .ts_sync(ts_sync), .ts_err(ts_err),
    .ts_data(ts_data)
  );

  always_ff @(posedge clk) begin
    if (rst) ts_oe <= 1'b0;
    else     ts_oe <= ~out_hiz;
  end

  assert_hiz_release_R8: assert property (@(posedge clk) disable iff (rst)
    $past(out_hiz) |-> !ts_oe);
endmodule

// File: tb/ts_stream_out_tb.sv
`timescale 1ns/1ps
module ts_stream_out_tb_top;
  localparam int PKT  = 188;
  localparam int MAXS = PKT * 8;

  // {serial, uncorrectable, gaps, seed}
  localparam logic [10:0] VEC [0:4] = '{
    {1'b0, 1'b0, 1'b0, 8'h35},
    {1'b0, 1'b1, 1'b1, 8'h12},
    {1'b1, 1'b1, 1'b0, 8'hA5},
    {1'b1, 1'b0, 1'b1, 8'h6C},
    {1'b0, 1'b1, 1'b0, 8'hFF}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0, in_uncorr = 1'b0;
  logic mode_serial = 1'b0, out_hiz = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, ts_clk, ts_valid, ts_sync, ts_err, ts_oe;
  logic [7:0] ts_data;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic rdy_after_first;

  logic [7:0] sym_d [0:MAXS-1];
  logic       sym_s [0:MAXS-1];
  logic       sym_e [0:MAXS-1];
  int sym_n = 0;

  always #2.5 clk = ~clk;

  ts_stream_out #(.PKT_BYTES(PKT), .DATA_W(8)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_uncorr(in_uncorr),
    .mode_serial(mode_serial), .out_hiz(out_hiz), .ts_clk(ts_clk),
    .ts_valid(ts_valid), .ts_sync(ts_sync), .ts_err(ts_err),
    .ts_data(ts_data), .ts_oe(ts_oe)
  );

  always @(negedge clk) begin
    if (ts_clk) begin
      if (sym_n < MAXS) begin
        sym_d[sym_n] = ts_data;
        sym_s[sym_n] = ts_sync;
        sym_e[sym_n] = ts_err;
      end
      sym_n = sym_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] raw_byte(input logic [7:0] seed, input int i);
    if (i == 0) return 8'h47;
    if (i == 1) return seed;
    return 8'(int'(seed) * 3 + i * 13);
  endfunction

  function automatic logic [7:0] out_byte(input logic [7:0] seed, input int i, input bit unc);
    logic [7:0] b = raw_byte(seed, i);
    if (unc && i == 1) b[7] = 1'b1;
    return b;
  endfunction

  task automatic send_pkt(input bit ser, input bit unc, input logic [7:0] seed,
                          input bit gaps, input bit flip);
    mode_serial = ser;
    for (int i = 0; i < PKT; i++) begin
      in_valid  = 1'b1;
      in_data   = raw_byte(seed, i);
      in_sop    = (i == 0);
      in_uncorr = (i == 0) ? unc : ~unc;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (i == 0) rdy_after_first = in_ready;
      in_valid = 1'b0;
      if (flip && i == 50) mode_serial = ~ser;
      if (gaps && (i % 17) == 5) repeat (3) @(negedge clk);
    end
    in_sop = 1'b0;
    in_uncorr = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  task automatic verify(input bit ser, input bit unc, input logic [7:0] seed);
    int nsym = ser ? PKT * 8 : PKT;
    int dbad = 0, sbad = 0, ebad = 0, lbad = 0;
    logic [7:0] b1 = '0;
    chk(sym_n == nsym, ser ? "R3 symbol count" : "R2 symbol count", sym_n, nsym);
    if (sym_n != nsym) return;
    for (int k = 0; k < PKT; k++) begin
      logic [7:0] got;
      if (ser) begin
        for (int j = 0; j < 8; j++) begin
          got[7-j] = sym_d[k*8+j][0];
          if (sym_d[k*8+j][7:1] != 7'd0) lbad++;
        end
      end else begin
        got = sym_d[k];
      end
      if (k == 1) b1 = got;
      else if (got != out_byte(seed, k, unc)) dbad++;
    end
    for (int j = 0; j < nsym; j++) begin
      if (sym_s[j] != (j == 0)) sbad++;
      if (sym_e[j] != unc) ebad++;
    end
    chk(dbad == 0, ser ? "R3 serial data" : "R2 parallel data", dbad, 0);
    if (ser) chk(lbad == 0, "R3 upper lines zero", lbad, 0);
    chk(b1 == out_byte(seed, 1, unc), "R6 header byte 1", b1, out_byte(seed, 1, unc));
    chk(sbad == 0, "R4 sync placement", sbad, 0);
    chk(ebad == 0, "R5 error strobe", ebad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state, R9 and R1
    repeat (3) @(negedge clk);
    chk({ts_clk, ts_valid, ts_sync, ts_err, ts_oe} == 5'b0, "R9 reset strobes",
        {ts_clk, ts_valid, ts_sync, ts_err, ts_oe}, 0);
    chk(ts_data == 8'h00, "R9 reset data", ts_data, 0);
    chk(in_ready == 1'b0, "R1 ready low in reset", in_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
    chk(ts_oe == 1'b1, "R8 drive enabled", ts_oe, 1);

    // table of vectors
    for (int v = 0; v < 5; v++) begin
      sym_n = 0;
      send_pkt(VEC[v][10], VEC[v][9], VEC[v][7:0], VEC[v][8], 1'b0);
      chk(rdy_after_first == 1'b0, "R1 ready drops after take", rdy_after_first, 0);
      verify(VEC[v][10], VEC[v][9], VEC[v][7:0]);
      chk(!ts_valid && !ts_clk, "R10 idle after packet", {ts_valid, ts_clk}, 0);
    end

    // R7: format switch requested mid-packet
    sym_n = 0;
    send_pkt(1'b0, 1'b0, 8'h21, 1'b0, 1'b1);
    chk(sym_n == PKT, "R7 packet kept parallel", sym_n, PKT);
    verify(1'b0, 1'b0, 8'h21);
    sym_n = 0;
    send_pkt(1'b1, 1'b0, 8'h43, 1'b0, 1'b0);
    chk(sym_n == PKT * 8, "R7 next packet serial", sym_n, PKT * 8);
    verify(1'b1, 1'b0, 8'h43);

    // R8: release pads during a packet
    sym_n = 0;
    fork
      send_pkt(1'b0, 1'b1, 8'h5A, 1'b0, 1'b0);
      begin
        repeat (30) @(negedge clk);
        out_hiz = 1'b1;
        @(negedge clk);
        chk(ts_oe == 1'b0, "R8 released", ts_oe, 0);
        repeat (10) @(negedge clk);
        chk(ts_valid == 1'b1, "R8 flow continues", ts_valid, 1);
        out_hiz = 1'b0;
        @(negedge clk);
        chk(ts_oe == 1'b1, "R8 driven again", ts_oe, 1);
      end
    join
    verify(1'b0, 1'b1, 8'h5A);

    // R9: reset mid-packet, next byte starts a packet
    mode_serial = 1'b0;
    for (int i = 0; i < 20; i++) begin
      in_valid = 1'b1; in_data = raw_byte(8'h33, i); in_sop = (i == 0); in_uncorr = 1'b0;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
    end
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    sym_n = 0;
    send_pkt(1'b0, 1'b1, 8'h0C, 1'b0, 1'b0);
    verify(1'b0, 1'b1, 8'h0C);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule